// File: doc/BRIEF.md
# Rotate-and-Mask Logic Unit

This unit forms the result of the 32-bit word rotate-and-mask operations of a 64-bit integer datapath. The low word of the source operand is duplicated into both halves of a 64-bit value, and that value is rotated left. The rotated value is then either ANDed with a generated mask or merged into the destination's previous contents under that mask. The mask is described by two 5-bit indices, a begin and an end. When the end index is below the begin index the run of ones wraps around, and the upper half of the mask is then set as well.

A 2-bit operation code selects one of three variants: AND with an immediate rotate amount, AND with a rotate amount taken from a register, or insert under mask. The rotate, mask and merge logic is combinational. By default one output register stage follows it, loaded only when `op_valid` is high. Reset is asynchronous and active-low. Inside the block its release is synchronised over two clock edges.

Top module: `rotmask_unit`

## Requirements
- R1: Mask indices count from the most significant bit of the low word, so index k names result bit 31-k. When `mask_end >= mask_begin`, mask bits 31-`mask_end` through 31-`mask_begin` are one and every other bit of the 64-bit mask is zero.
- R2: When `mask_end < mask_begin`, mask bits 32-`mask_begin` through 30-`mask_end` are zero and all other bits are one, including all of bits 63:32. For `mask_end == mask_begin-1` the mask is all ones. These upper ones reach the result unchanged.
- R3: The value that is rotated is `{src_val[31:0], src_val[31:0]}`, rotated left as one 64-bit quantity. `src_val[63:32]` has no effect on the result.
- R4: A rotate amount of zero leaves the duplicated source unrotated, so that with mask indices 0 and 31 the result equals `src_val[31:0]` zero-extended.
- R5: `op_sel` = 2'b00 (immediate AND) gives rotated AND mask, with the rotate amount taken from `amt_imm`.
- R6: `op_sel` = 2'b01 (register AND) gives rotated AND mask, with the rotate amount taken from `amt_reg[4:0]`. `amt_reg[63:5]` and `amt_imm` have no effect.
- R7: `op_sel` = 2'b10 (insert) gives `(old_val & ~mask) | (rotated & mask)`, with the rotate amount taken from `amt_imm`.
- R8: `op_sel` = 2'b11 is reserved and gives a zero result.
- R9: With the output stage present, `result` and `res_valid` show the outcome of an operation one clock after `op_valid` is sampled high. While `op_valid` is low, `res_valid` is low on the following clock and `result` holds its value.
- R10: While reset is asserted, `result` is zero and `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present; enables the output stage |
| op_sel | input | 2 | 00 immediate AND, 01 register AND, 10 insert, 11 reserved |
| src_val | input | 64 | Source operand; only the low word is used |
| old_val | input | 64 | Destination's previous value, used by insert |
| amt_reg | input | 64 | Register operand that supplies the rotate amount (low 5 bits) |
| amt_imm | input | 5 | Immediate rotate amount |
| mask_begin | input | 5 | First mask index, counted from the word's MSB |
| mask_end | input | 5 | Last mask index, counted from the word's MSB |
| res_valid | output | 1 | Result valid |
| result | output | 64 | Operation result |

## Verification
Directed vectors first separate the plain mask (begin no greater than end) from the wrapped mask, including the single-bit case and the all-ones case where end is one below begin, so that an error in the carry term or in the arithmetic fill of the mask generator is visible. A zero rotate with a full mask, and a source with a busy upper word, show whether the word is duplicated and whether the upper source half leaks into the result. A register-AND vector with set high bits in the amount register and a conflicting immediate shows which amount source is used. Insert vectors with a patterned old value, the reserved code, idle cycles with changed inputs, and a long pseudo-random mix across all four codes complete the set, all compared each clock against a bit-loop reference model.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;

  typedef enum logic [1:0] {
    OP_AND_IMM = 2'b00,
    OP_AND_REG = 2'b01,
    OP_INSERT  = 2'b10,
    OP_RSVD    = 2'b11
  } rm_op_e;

endpackage

// File: rtl/rotmask_mask_gen.sv
// Builds the 64-bit mask from begin/end indices counted from the word MSB.
// Three terms are summed; the carries out of the sum close the wrapped case.
module rotmask_mask_gen #(
  parameter int WORD_W = 32,
  localparam int DATA_W = 2 * WORD_W,
  localparam int IDX_W  = $clog2(WORD_W)
) (
  input  logic [IDX_W-1:0]  idx_begin,
  input  logic [IDX_W-1:0]  idx_end,
  output logic [DATA_W-1:0] mask
);

  localparam logic [DATA_W-1:0] LOW_ONES  = {{WORD_W{1'b0}}, {WORD_W{1'b1}}};
  localparam logic [DATA_W-1:0] TOP_FILL  = {{(WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};

  logic [DATA_W-1:0] head_term;
  logic [DATA_W-1:0] tail_term;
  logic [DATA_W-1:0] carry_term;

  always_comb begin
    head_term  = LOW_ONES >> idx_begin;
    tail_term  = DATA_W'($signed(TOP_FILL) >>> idx_end);
    carry_term = DATA_W'(idx_end >= idx_begin);
    mask       = head_term + tail_term + carry_term;
  end

endmodule

// File: rtl/rotmask_rotator.sv
// Duplicates the word into both halves, then rotates left by a log-stage barrel.
module rotmask_rotator #(
  parameter int WORD_W = 32,
  localparam int DATA_W = 2 * WORD_W,
  localparam int IDX_W  = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic [IDX_W-1:0]  amount,
  output logic [DATA_W-1:0] rotated
);

  logic [DATA_W-1:0] stage [IDX_W+1];

  assign stage[0] = {word_in, word_in};

  for (genvar k = 0; k < IDX_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stage[k+1] = amount[k]
                      ? {stage[k][DATA_W-SH-1:0], stage[k][DATA_W-1:DATA_W-SH]}
                      : stage[k];
  end

  assign rotated = stage[IDX_W];

endmodule

// File: rtl/rotmask_merge.sv
// Applies the mask according to the selected variant.
module rotmask_merge
  import rotmask_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  rm_op_e            op,
  input  logic [DATA_W-1:0] rotated,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] old_val,
  output logic [DATA_W-1:0] merged
);

  always_comb begin
    unique case (op)
      OP_AND_IMM,
      OP_AND_REG: merged = rotated & mask;
      OP_INSERT:  merged = (old_val & ~mask) | (rotated & mask);
      default:    merged = '0;
    endcase
  end

endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
  import rotmask_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int DATA_W = 2 * WORD_W,
  localparam int IDX_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_sel,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] amt_reg,
  input  logic [IDX_W-1:0]  amt_imm,
  input  logic [IDX_W-1:0]  mask_begin,
  input  logic [IDX_W-1:0]  mask_end,
  output logic              res_valid,
  output logic [DATA_W-1:0] result
);

  // Reset: asserted asynchronously, released on the second clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Operand selection
  rm_op_e           op;
  logic [IDX_W-1:0] rot_amt;
  logic             unused_bits;

  assign op          = rm_op_e'(op_sel);
  assign rot_amt     = (op == OP_AND_REG) ? amt_reg[IDX_W-1:0] : amt_imm;
  assign unused_bits = ^{amt_reg[DATA_W-1:IDX_W], src_val[DATA_W-1:WORD_W]};

  logic [DATA_W-1:0] rot_w;
  logic [DATA_W-1:0] mask_w;
  logic [DATA_W-1:0] comb_res;

  rotmask_rotator #(.WORD_W(WORD_W)) u_rot (
    .word_in (src_val[WORD_W-1:0]),
    .amount  (rot_amt),
    .rotated (rot_w)
  );

  rotmask_mask_gen #(.WORD_W(WORD_W)) u_mask (
    .idx_begin (mask_begin),
    .idx_end   (mask_end),
    .mask      (mask_w)
  );

  rotmask_merge #(.DATA_W(DATA_W)) u_merge (
    .op      (op),
    .rotated (rot_w),
    .mask    (mask_w),
    .old_val (old_val),
    .merged  (comb_res)
  );

  if (REG_OUT) begin : g_reg_out
    logic [DATA_W-1:0] res_d, res_q;
    logic              vld_d, vld_q;

    always_comb begin
      vld_d = op_valid;
      res_d = res_q;
      if (op_valid) res_d = comb_res;
    end

    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) begin
        res_q <= '0;
        vld_q <= 1'b0;
      end else begin
        res_q <= res_d;
        vld_q <= vld_d;
      end
    end

    assign result    = res_q;
    assign res_valid = vld_q;
  end else begin : g_comb_out
    assign result    = comb_res;
    assign res_valid = op_valid;
  end

endmodule

// File: rtl/rotmask_unit_chk.sv
module rotmask_unit_chk #(
  parameter int WORD_W  = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int DATA_W = 2 * WORD_W,
  localparam int IDX_W  = $clog2(WORD_W)
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              op_valid,
  input logic [1:0]        op_sel,
  input logic [DATA_W-1:0] old_val,
  input logic [IDX_W-1:0]  mask_begin,
  input logic [IDX_W-1:0]  mask_end,
  input logic [DATA_W-1:0] mask_w,
  input logic              res_valid,
  input logic [DATA_W-1:0] result
);

  // R1: plain mask never touches the upper half
  a_r1_plain_mask_low: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mask_end >= mask_begin) |-> (mask_w[DATA_W-1:WORD_W] == '0));

  // R2: wrapped mask fills the upper half
  a_r2_wrap_mask_high: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mask_end < mask_begin) |-> (&mask_w[DATA_W-1:WORD_W]));

  if (REG_OUT) begin : g_seq
    // R9
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_int_n)
      op_valid |=> res_valid);
    a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_int_n)
      !op_valid |=> !res_valid);
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
      !op_valid |=> $stable(result));

    // R5 / R6: AND variants leave nothing outside the mask
    a_r5_and_within_mask: assert property (@(posedge clk) disable iff (!rst_int_n)
      (op_valid && !op_sel[1]) |=> ((result & ~$past(mask_w)) == '0));

    // R7: insert keeps old bits outside the mask
    a_r7_insert_keeps_old: assert property (@(posedge clk) disable iff (!rst_int_n)
      (op_valid && op_sel == 2'b10) |=> (((result ^ $past(old_val)) & ~$past(mask_w)) == '0));

    // R8: reserved code gives zero
    a_r8_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
      (op_valid && op_sel == 2'b11) |=> (result == '0));
  end else begin : g_comb
    always_comb begin
      if (rst_int_n && op_valid && op_sel == 2'b11)
        a_r8_rsvd_zero_c: assert (result == '0);
    end
  end

endmodule

bind rotmask_unit rotmask_unit_chk #(.WORD_W(WORD_W), .REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst_int_n  (rst_int_n),
  .op_valid   (op_valid),
  .op_sel     (op_sel),
  .old_val    (old_val),
  .mask_begin (mask_begin),
  .mask_end   (mask_end),
  .mask_w     (mask_w),
  .res_valid  (res_valid),
  .result     (result)
);

// File: tb/sim_rotmask_unit.sv
`timescale 1ns/1ps
module sim_rotmask_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [1:0]  op_sel;
  logic [63:0] src_val, old_val, amt_reg;
  logic [4:0]  amt_imm, mask_begin, mask_end;
  logic        res_valid;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [63:0] exp_res;
  logic        exp_vld;
  string       exp_tag;

  always #5 clk = ~clk;

  rotmask_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .src_val(src_val), .old_val(old_val), .amt_reg(amt_reg), .amt_imm(amt_imm),
    .mask_begin(mask_begin), .mask_end(mask_end),
    .res_valid(res_valid), .result(result)
  );

  // Behavioural reference
  function automatic logic [63:0] ref_mask(input int b, input int e);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) begin
      if (e >= b) m[i] = (i >= 31 - e) && (i <= 31 - b);
      else        m[i] = !((i >= 32 - b) && (i <= 30 - e));
    end
    return m;
  endfunction

  function automatic logic [63:0] ref_calc(input logic [1:0] op, input logic [63:0] s,
      input logic [63:0] o, input logic [63:0] ar, input int ai, input int b, input int e);
    logic [63:0] r, m;
    int n;
    r = {s[31:0], s[31:0]};
    n = (op == 2'b01) ? int'(ar % 32) : ai;
    for (int k = 0; k < n; k++) r = {r[62:0], r[63]};
    m = ref_mask(b, e);
    case (op)
      2'b00, 2'b01: return r & m;
      2'b10:        return (o & ~m) | (r & m);
      default:      return 64'd0;
    endcase
  endfunction

  task automatic check_out();
    checks++;
    if (res_valid !== exp_vld || result !== exp_res) begin
      errors++;
      $display("FAIL %s: result=%h valid=%b expected result=%h valid=%b",
               exp_tag, result, res_valid, exp_res, exp_vld);
    end
  endtask

  // One clock: check what the previous drive produced, then drive the next one.
  task automatic step(input logic v, input logic [1:0] op, input logic [63:0] s,
      input logic [63:0] o, input logic [63:0] ar, input logic [4:0] ai,
      input logic [4:0] b, input logic [4:0] e, input string tag);
    @(negedge clk);
    check_out();
    op_valid = v; op_sel = op; src_val = s; old_val = o;
    amt_reg = ar; amt_imm = ai; mask_begin = b; mask_end = e;
    exp_vld = v;
    if (v) exp_res = ref_calc(op, s, o, ar, int'(ai), int'(b), int'(e));
    exp_tag = tag;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: result=%h expected completion", result);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_sel = 2'b00;
    src_val = '0; old_val = '0; amt_reg = '0; amt_imm = '0;
    mask_begin = '0; mask_end = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    exp_res = '0; exp_vld = 1'b0; exp_tag = "R10 reset";
    check_out();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_tag = "R10 after release";
    check_out();

    // R1 plain mask, R5 immediate AND
    step(1, 2'b00, 64'h0000_0000_1234_5678, '0, '0, 5'd0,  5'd8,  5'd23, "R1 plain mask");
    step(1, 2'b00, 64'h0000_0000_8000_0001, '0, '0, 5'd4,  5'd0,  5'd31, "R5 imm rotate 4");
    step(1, 2'b00, 64'h0000_0000_FFFF_FFFF, '0, '0, 5'd0,  5'd13, 5'd13, "R1 single bit");
    // R4 zero rotate, full mask
    step(1, 2'b00, 64'hDEAD_BEEF_CAFE_F00D, '0, '0, 5'd0,  5'd0,  5'd31, "R4 zero rotate");
    // R3 duplicate and upper source ignored
    step(1, 2'b00, 64'hFFFF_FFFF_0123_4567, '0, '0, 5'd8,  5'd28, 5'd3,  "R3 duplicate word");
    step(1, 2'b00, 64'h5555_0000_0123_4567, '0, '0, 5'd8,  5'd28, 5'd3,  "R3 upper src ignored");
    // R2 wrapped mask, all-ones case
    step(1, 2'b00, 64'h0000_0000_F00F_00FF, '0, '0, 5'd12, 5'd31, 5'd0,  "R2 wrapped mask");
    step(1, 2'b00, 64'h0000_0000_89AB_CDEF, '0, '0, 5'd5,  5'd5,  5'd4,  "R2 all ones");
    // R6 register amount, high bits and immediate ignored
    step(1, 2'b01, 64'h0000_0000_0000_00F1, '0, 64'hFFFF_FFFF_FFFF_FFE3, 5'd17, 5'd0, 5'd31, "R6 reg amount");
    step(1, 2'b01, 64'h0000_0000_1357_9BDF, '0, 64'h0000_0001_0000_0000, 5'd9,  5'd0, 5'd31, "R6 reg zero low bits");
    // R7 insert
    step(1, 2'b10, 64'h0000_0000_ABCD_1234, 64'hA5A5_A5A5_5A5A_5A5A, '0, 5'd16, 5'd8, 5'd15, "R7 insert plain");
    step(1, 2'b10, 64'h0000_0000_ABCD_1234, 64'h0123_4567_89AB_CDEF, '0, 5'd3,  5'd30, 5'd1, "R7 insert wrapped");
    // R8 reserved
    step(1, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, '1, 5'd1, 5'd0, 5'd31, "R8 reserved code");
    step(1, 2'b00, 64'h0000_0000_0F0F_0F0F, '0, '0, 5'd1, 5'd0, 5'd31, "R5 before idle");
    // R9 idle hold with changed inputs
    step(0, 2'b10, 64'h1111_2222_3333_4444, 64'h9999_8888_7777_6666, '1, 5'd7, 5'd30, 5'd2, "R9 idle hold");
    step(0, 2'b00, 64'h0, 64'h0, '0, 5'd0, 5'd0, 5'd0, "R9 idle hold 2");
    step(1, 2'b10, 64'h0000_0000_0000_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, '0, 5'd0, 5'd16, 5'd31, "R9 resume");

    // Pseudo-random mix across all codes
    for (int i = 0; i < 400; i++) begin
      logic [1:0] op;
      string t;
      op = 2'($urandom);
      case (op)
        2'b00: t = "R5 random imm AND";
        2'b01: t = "R6 random reg AND";
        2'b10: t = "R7 random insert";
        default: t = "R8 random reserved";
      endcase
      step(($urandom % 8) != 0, op, {$urandom, $urandom}, {$urandom, $urandom},
           {$urandom, $urandom}, 5'($urandom), 5'($urandom), 5'($urandom), t);
    end
    step(0, 2'b00, '0, '0, '0, '0, '0, '0, "R9 final idle");
    @(negedge clk);
    check_out();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule